// File: doc/BRIEF.md
# Memory Bit Test and Modify Sequencer

This block carries out a single-bit test, set, clear or invert on data held in memory, where the bit is named by a byte base address and a bit distance from bit 0 of that byte. The distance comes either from a signed 32-bit value, which may point below the base, or from an 8-bit immediate that is reduced to the element width. The unit turns the distance into a word-aligned (relative to the base) element address and a bit index. It reads the whole element, reports the old bit as carry, and, for the modifying operations, writes the element back with only that bit changed.

The memory side is a simple request/valid handshake. The request and its address are held until the memory raises valid. A lock output covers both the read and the write back, so the memory side can keep the pair atomic. A new operation is accepted only when the unit is idle.

Top module: `bit_rmw_seq`

## Requirements
- R1: After reset, busy, done, carry, mem_req and mem_lock are all 0.
- R2: In 32-bit mode (wide=1) with a register offset, mem_addr is base_addr + 4 × (offset arithmetically shifted right by 5), the bit index is offset[4:0], and mem_wide is 1.
- R3: In 16-bit mode (wide=0) with a register offset, mem_addr is base_addr + 2 × (offset arithmetically shifted right by 4), the bit index is offset[3:0], mem_wide is 0, and mem_wdata[31:16] is 0 on a write.
- R4: A negative offset reaches below the base: offset −1 in 32-bit mode gives address base_addr − 4 and bit 31, and in 16-bit mode gives base_addr − 2 and bit 15.
- R5: With use_imm=1, mem_addr is base_addr, and the bit index is imm_offset modulo 32 (wide) or modulo 16 (narrow).
- R6: op 2'b00 tests only: no write is issued, and done pulses for one cycle in the cycle after the read valid, with carry equal to the selected bit of mem_rdata.
- R7: op 2'b01 sets, 2'b10 clears and 2'b11 inverts the selected bit. The write goes to the read address, and the written data equals the read data with only that bit changed. Carry holds the old bit, and done pulses in the cycle after the write valid.
- R8: While mem_req is high and mem_valid is low, mem_req, mem_addr and mem_we stay unchanged in the next cycle.
- R9: When lock_req is 1 at start, mem_lock is high for every cycle of the read and the write back. When lock_req is 0, mem_lock stays 0.
- R10: A start pulse that arrives while busy is 1 is ignored: the running operation completes with its own address, data and carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| op | input | 2 | 00 test, 01 set, 10 clear, 11 invert |
| base_addr | input | 32 | Byte address whose bit 0 is distance 0 |
| offset | input | 32 | Signed bit distance |
| imm_offset | input | 8 | Immediate bit distance |
| use_imm | input | 1 | Select imm_offset instead of offset |
| wide | input | 1 | 1: 32-bit element, 0: 16-bit element |
| lock_req | input | 1 | Keep read and write back atomic |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| carry | output | 1 | Old value of the selected bit |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_wide | output | 1 | Access width: 1 full doubleword, 0 word |
| mem_lock | output | 1 | Atomic pair in progress |
| mem_addr | output | 32 | Element address |
| mem_wdata | output | 32 | Write data |
| mem_valid | input | 1 | Memory accepted or answered the request |
| mem_rdata | input | 32 | Read data, valid with mem_valid |

## Verification
The assertions check on every cycle that a pending request holds still, that a write changes at most one bit of the element just read and targets its address, that a test never writes, that the lock spans the read-to-write gap, that narrow writes carry zero upper halves, and that done is a lone pulse. Only the bench's scenarios can show the arithmetic: which element address and bit a given positive, negative or immediate distance selects in each width, that carry is the right bit, and that a start pulse while busy leaves the operation unchanged.

// File: rtl/bit_rmw_pkg.sv
// Shared encodings for the bit test and modify sequencer.
// Assumes: op encoding is fixed by the caller's decoder (two low bits).
package bit_rmw_pkg;
    typedef enum logic [1:0] {
        BOP_TEST = 2'b00,
        BOP_SET  = 2'b01,
        BOP_CLR  = 2'b10,
        BOP_FLIP = 2'b11
    } bop_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_DONE
    } st_e;
endpackage

// File: rtl/bit_rmw_addr.sv
// Turns a base byte address plus a bit distance into an element address
// and a bit index within the element.
// Assumes: DATA_W is a power of two >= 16; IMM_W >= log2(DATA_W);
// ADDR_W >= OFF_W (the displacement is sign-extended).
module bit_rmw_addr #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 32,
    parameter int IMM_W  = 8,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [OFF_W-1:0]  offset,
    input  logic [IMM_W-1:0]  imm,
    input  logic              use_imm,
    input  logic              wide,
    output logic [ADDR_W-1:0] elem_addr,
    output logic [IDX_W-1:0]  bit_idx
);
    // Byte scale of one element: log2 of bytes per element.
    localparam int WSCALE = IDX_W - 3;
    localparam int NSCALE = IDX_W - 4;

    logic signed [OFF_W-1:0]  soff;
    logic signed [OFF_W-1:0]  elem_w, elem_n;
    logic        [ADDR_W-1:0] disp_w, disp_n;
    logic        [IDX_W-1:0]  imm_bit, reg_bit;

    // Element displacement for both widths (arithmetic: reaches below base).
    always_comb begin
        soff   = offset;
        elem_w = soff >>> IDX_W;
        elem_n = soff >>> (IDX_W - 1);
        disp_w = ADDR_W'(elem_w <<< WSCALE);
        disp_n = ADDR_W'(elem_n <<< NSCALE);
    end

    // Bit index: low bits of the distance, narrowed in 16-bit mode.
    always_comb begin
        imm_bit = wide ? imm[IDX_W-1:0] : {1'b0, imm[IDX_W-2:0]};
        reg_bit = wide ? offset[IDX_W-1:0] : {1'b0, offset[IDX_W-2:0]};
        bit_idx = use_imm ? imm_bit : reg_bit;
    end

    // Address: an immediate never leaves the base element.
    always_comb begin
        if (use_imm) elem_addr = base;
        else         elem_addr = base + (wide ? disp_w : disp_n);
    end
endmodule

// File: rtl/bit_rmw_alu.sv
// Extracts the selected bit of a read element and forms the write-back
// value for set, clear or invert; narrow elements return zero upper bits.
// Assumes: bit_idx < DATA_W/2 whenever wide is 0.
module bit_rmw_alu
    import bit_rmw_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(DATA_W),
    localparam int HALF  = DATA_W / 2
) (
    input  logic [DATA_W-1:0] rdata,
    input  logic [IDX_W-1:0]  bit_idx,
    input  bop_e              op,
    input  logic              wide,
    output logic              old_bit,
    output logic [DATA_W-1:0] wdata
);
    logic [DATA_W-1:0] sel_mask, keep_mask, modified;

    // One-hot mask of the selected bit.
    always_comb sel_mask = {{(DATA_W-1){1'b0}}, 1'b1} << bit_idx;

    // Width mask built per bit: upper half dropped for narrow elements.
    for (genvar g = 0; g < DATA_W; g++) begin : g_keep
        if (g < HALF) begin : g_lo
            assign keep_mask[g] = 1'b1;
        end else begin : g_hi
            assign keep_mask[g] = wide;
        end
    end

    // Old bit and modified element.
    always_comb begin
        old_bit = |(rdata & sel_mask);
        case (op)
            BOP_SET:  modified = rdata | sel_mask;
            BOP_CLR:  modified = rdata & ~sel_mask;
            BOP_FLIP: modified = rdata ^ sel_mask;
            default:  modified = rdata;
        endcase
        wdata = modified & keep_mask;
    end
endmodule

// File: rtl/bit_rmw_seq.sv
// Sequencer for one bit test/modify on memory: latch the request, read
// the whole element, report the old bit, write back if modifying.
// Assumes: memory answers each request with one mem_valid cycle and
// honours mem_lock to keep the read and the write back atomic.
module bit_rmw_seq
    import bit_rmw_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 32,
    parameter int IMM_W  = 8,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        op,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [OFF_W-1:0]  offset,
    input  logic [IMM_W-1:0]  imm_offset,
    input  logic              use_imm,
    input  logic              wide,
    input  logic              lock_req,
    output logic              busy,
    output logic              done,
    output logic              carry,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_wide,
    output logic              mem_lock,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_valid,
    input  logic [DATA_W-1:0] mem_rdata
);
    st_e               st_q;
    bop_e              op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [IDX_W-1:0]  idx_q;
    logic              wide_q, lock_q, carry_q;
    logic [DATA_W-1:0] wdata_q;

    logic [ADDR_W-1:0] calc_addr;
    logic [IDX_W-1:0]  calc_idx;
    logic              alu_old;
    logic [DATA_W-1:0] alu_wdata;

    bit_rmw_addr #(
        .ADDR_W(ADDR_W), .OFF_W(OFF_W), .IMM_W(IMM_W), .DATA_W(DATA_W)
    ) u_addr (
        .base     (base_addr),
        .offset   (offset),
        .imm      (imm_offset),
        .use_imm  (use_imm),
        .wide     (wide),
        .elem_addr(calc_addr),
        .bit_idx  (calc_idx)
    );

    bit_rmw_alu #(.DATA_W(DATA_W)) u_alu (
        .rdata  (mem_rdata),
        .bit_idx(idx_q),
        .op     (op_q),
        .wide   (wide_q),
        .old_bit(alu_old),
        .wdata  (alu_wdata)
    );

    // Sequence: accept, read, optional write back, completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            op_q    <= BOP_TEST;
            addr_q  <= '0;
            idx_q   <= '0;
            wide_q  <= 1'b0;
            lock_q  <= 1'b0;
            carry_q <= 1'b0;
            wdata_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: if (start) begin
                    op_q   <= bop_e'(op);
                    addr_q <= calc_addr;
                    idx_q  <= calc_idx;
                    wide_q <= wide;
                    lock_q <= lock_req;
                    st_q   <= ST_READ;
                end
                ST_READ: if (mem_valid) begin
                    carry_q <= alu_old;
                    wdata_q <= alu_wdata;
                    st_q    <= (op_q == BOP_TEST) ? ST_DONE : ST_WRITE;
                end
                ST_WRITE: if (mem_valid) st_q <= ST_DONE;
                default:  st_q <= ST_IDLE;
            endcase
        end
    end

    // Port decode from the state register.
    always_comb begin
        busy      = (st_q != ST_IDLE);
        done      = (st_q == ST_DONE);
        carry     = carry_q;
        mem_req   = (st_q == ST_READ) || (st_q == ST_WRITE);
        mem_we    = (st_q == ST_WRITE);
        mem_wide  = wide_q;
        mem_lock  = lock_q && mem_req;
        mem_addr  = addr_q;
        mem_wdata = wdata_q;
    end
endmodule

// File: rtl/bit_rmw_sva.sv
// Protocol and data checks for bit_rmw_seq, attached with bind.
// Assumes: the sequencer's port names are unchanged.
module bit_rmw_sva #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [1:0]        op,
    input logic              busy,
    input logic              done,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_wide,
    input logic              mem_lock,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_valid,
    input logic [DATA_W-1:0] mem_rdata
);
    localparam int HALF = DATA_W / 2;

    logic [DATA_W-1:0] rd_q;
    logic              tst_q;
    logic [DATA_W-1:0] keep;

    // Record the last read element and whether the accepted op is a test.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q  <= '0;
            tst_q <= 1'b0;
        end else begin
            if (mem_req && !mem_we && mem_valid) rd_q <= mem_rdata;
            if (start && !busy) tst_q <= (op == 2'b00);
        end
    end

    always_comb keep = mem_wide ? {DATA_W{1'b1}} : {{HALF{1'b0}}, {HALF{1'b1}}};

    p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_valid |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    p_one_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> $countones((mem_wdata ^ rd_q) & keep) <= 1);

    p_same_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_we && mem_valid |=> !mem_req || mem_addr == $past(mem_addr));

    p_test_nowrite_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tst_q && mem_req |-> !mem_we);

    p_lock_span_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_lock && mem_valid && !mem_we |=> mem_lock || done);

    p_narrow_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we && !mem_wide |-> mem_wdata[DATA_W-1:HALF] == '0);

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy);
endmodule

bind bit_rmw_seq bit_rmw_sva #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sva (.*);

// File: tb/bit_rmw_seq_tb.sv
`timescale 1ns/100ps
module bit_rmw_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op = 2'b00;
    logic [31:0] base_addr = '0;
    logic [31:0] offset = '0;
    logic [7:0]  imm_offset = '0;
    logic        use_imm = 1'b0;
    logic        wide = 1'b1;
    logic        lock_req = 1'b0;
    logic        busy, done, carry, mem_req, mem_we, mem_wide, mem_lock;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_valid = 1'b0;
    logic [31:0] mem_rdata = '0;

    int n_chk = 0;
    int n_bad = 0;
    int lat = 1;
    bit finished = 0;

    typedef struct {
        int          kind;   // 0 read, 1 write, 2 done
        logic [31:0] addr;
        logic [31:0] wdata;
        logic        wide;
        logic        lock;
        logic        carry;
        string       tag;
    } item_t;
    item_t exp_q[$];

    always #2.5 clk = ~clk;

    bit_rmw_seq u_dut (.*);

    function automatic logic [31:0] mem_fn(logic [31:0] a);
        return (a * 32'h9E3779B1) ^ 32'h5A0FC3E1;
    endfunction

    // Memory model: answers after lat waiting cycles, one valid cycle each.
    initial begin
        int cnt = 0;
        forever begin
            @(negedge clk);
            #0.5;
            if (mem_valid) begin
                mem_valid = 1'b0;
                cnt = 0;
            end else if (mem_req) begin
                if (cnt >= lat) begin
                    mem_valid = 1'b1;
                    mem_rdata = mem_fn(mem_addr);
                end else cnt++;
            end
        end
    end

    // Monitor: compare each handshake and completion with the queue.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (mem_req && mem_valid) begin
                item_t e;
                n_chk++;
                if (exp_q.size() == 0) begin
                    n_bad++;
                    $display("FAIL unexpected access addr=%h we=%b exp=none", mem_addr, mem_we);
                end else begin
                    e = exp_q.pop_front();
                    if (e.kind != int'(mem_we) || e.addr != mem_addr ||
                        e.wide != mem_wide || e.lock != mem_lock ||
                        (e.kind == 1 && e.wdata != mem_wdata)) begin
                        n_bad++;
                        $display("FAIL %s access: got we=%b addr=%h wide=%b lock=%b wd=%h exp kind=%0d addr=%h wide=%b lock=%b wd=%h",
                                 e.tag, mem_we, mem_addr, mem_wide, mem_lock, mem_wdata,
                                 e.kind, e.addr, e.wide, e.lock, e.wdata);
                    end
                end
            end
            if (done) begin
                item_t e;
                n_chk++;
                if (exp_q.size() == 0) begin
                    n_bad++;
                    $display("FAIL unexpected done carry=%b exp=none", carry);
                end else begin
                    e = exp_q.pop_front();
                    if (e.kind != 2 || e.carry != carry) begin
                        n_bad++;
                        $display("FAIL %s done: got carry=%b exp kind=%0d carry=%b",
                                 e.tag, carry, e.kind, e.carry);
                    end
                end
            end
        end
    end

    // Driver: predict the transaction list, then launch the operation.
    task automatic run_op(input string tag, input logic [31:0] b, input logic [31:0] off,
                          input logic [7:0] im, input logic ui, input logic w,
                          input logic [1:0] o, input logic lk, input int l,
                          input bit poke_busy);
        logic [31:0] a, rd, wd;
        int          bi;
        logic        nv;
        item_t       it;
        if (ui) begin
            a  = b;
            bi = w ? int'(im) % 32 : int'(im) % 16;
        end else if (w) begin
            a  = b + 32'(($signed(off) >>> 5) * 4);
            bi = int'(off[4:0]);
        end else begin
            a  = b + 32'(($signed(off) >>> 4) * 2);
            bi = int'(off[3:0]);
        end
        rd = mem_fn(a);
        case (o)
            2'b01:   nv = 1'b1;
            2'b10:   nv = 1'b0;
            2'b11:   nv = ~rd[bi];
            default: nv = rd[bi];
        endcase
        wd = rd;
        wd[bi] = nv;
        if (!w) wd[31:16] = '0;
        it = '{0, a, 32'h0, w, lk, 1'b0, tag};
        exp_q.push_back(it);
        if (o != 2'b00) begin
            it = '{1, a, wd, w, lk, 1'b0, tag};
            exp_q.push_back(it);
        end
        it = '{2, 32'h0, 32'h0, 1'b0, 1'b0, rd[bi], tag};
        exp_q.push_back(it);

        lat = l;
        @(negedge clk);
        base_addr = b; offset = off; imm_offset = im; use_imm = ui;
        wide = w; op = o; lock_req = lk; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke_busy) begin
            // R10: a second start with other operands while busy
            base_addr = 32'hDEAD_0000; offset = 32'h0000_0123; op = ~o;
            wide = ~w; lock_req = ~lk; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
        n_chk++;
        if (busy) begin
            n_bad++;
            $display("FAIL %s R10 busy after completion: got 1 exp 0", tag);
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired: got hang exp completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        n_chk++;
        // R1: reset state
        if (busy || done || carry || mem_req || mem_lock) begin
            n_bad++;
            $display("FAIL R1 reset: got busy=%b done=%b carry=%b req=%b lock=%b exp all 0",
                     busy, done, carry, mem_req, mem_lock);
        end

        run_op("R2 wide test +5",       32'h0000_1000, 32'd5,          8'd0,   0, 1, 2'b00, 0, 1, 0);
        run_op("R2 wide set +100 R9",   32'h0000_1003, 32'd100,        8'd0,   0, 1, 2'b01, 1, 2, 0);
        run_op("R4 wide test -1",       32'h0000_2000, 32'hFFFF_FFFF,  8'd0,   0, 1, 2'b00, 0, 0, 0);
        run_op("R4 wide clear -200 R9", 32'h0000_3000, -32'sd200,      8'd0,   0, 1, 2'b10, 1, 3, 0);
        run_op("R7 wide flip +31",      32'h0000_4001, 32'd31,         8'd0,   0, 1, 2'b11, 0, 1, 0);
        run_op("R4 narrow flip -1",     32'h0000_5000, 32'hFFFF_FFFF,  8'd0,   0, 0, 2'b11, 0, 1, 0);
        run_op("R3 narrow set +37",     32'h0000_6002, 32'd37,         8'd0,   0, 0, 2'b01, 1, 0, 0);
        run_op("R3 narrow clear -33",   32'h0000_7000, -32'sd33,       8'd0,   0, 0, 2'b10, 0, 2, 0);
        run_op("R5 imm wide test 255",  32'h0000_8000, 32'h7FFF_0000,  8'hFF,  1, 1, 2'b00, 0, 1, 0);
        run_op("R5 imm narrow flip 77", 32'h0000_9000, 32'h8000_0000,  8'd77,  1, 0, 2'b11, 1, 2, 0);
        run_op("R5 imm wide set 45",    32'h0000_A005, 32'd999,        8'd45,  1, 1, 2'b01, 0, 0, 0);
        run_op("R10 busy start ignored",32'h0000_B000, 32'd70,         8'd0,   0, 1, 2'b01, 1, 3, 1);
        run_op("R6 test zero latency",  32'h0000_C000, 32'd12,         8'd0,   0, 1, 2'b00, 0, 0, 0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule